// File: doc/BRIEF.md
# DMA Channel Byte Counter and Status Tracker

This block follows a single DMA channel that moves data between a USB endpoint and a 32-bit system bus. A load strobe comes from a software control write or from a completed descriptor fetch. It supplies a start address, a 16-bit byte length, an enable bit and a load-next bit. For every bus beat, the block reports how many bytes the current access may carry. That number is limited by the word alignment of the running address and by the bytes still owed to the buffer. When a beat's address phase completes, the block lowers the remaining count by that width and advances the address.

The block keeps a 32-bit status word. It holds the remaining count, an enable status, an active status and three event flags, and the flags clear when the word is read. A length of zero selects unknown-length mode. In that mode the count wraps downward from zero and only the device can end the transfer. The number of bytes received is then available as the two's complement of the count. When the enable status drops while load-next is set, the block asks the descriptor engine for the next descriptor with a one-cycle pulse.

The bus master, the arbiter, the FIFO storage and the descriptor fetcher sit outside this block. It only sees their handshakes.

Top module: `dma_chan_tracker`

## Requirements
- R1: After reset, `stat_rdata`, `acc_bytes`, `rx_len` and `dsc_req` are all zero.
- R2: `acc_bytes` = min(4 − address[1:0], remaining count). A word-aligned address gives 4 while at least 4 bytes remain. A length of zero selects unknown-length mode, and there the limit is 4 − address[1:0] alone.
- R3: A beat is accepted when `beat`, `grant` and the enable status are all high and `acc_bytes` is non-zero. An accepted beat lowers the count by `acc_bytes` and adds `acc_bytes` to `acc_addr` at that clock edge. A beat without `grant` changes nothing.
- R4: In a known-length buffer, the beat that brings the count to zero sets the end-of-buffer flag (status bit 5) and clears the enable status (bit 0) at the same edge.
- R5: In unknown-length mode the count wraps modulo 2^16. `rx_len` equals (0x10000 − count) mod 2^16, and the end-of-buffer flag is never set.
- R6: A `dev_end` pulse while enabled sets the end-of-transfer flag (bit 4) and clears the enable status.
- R7: A load with `ld_from_dsc` high sets the descriptor-loaded flag (bit 6). A load from a software write leaves that flag unchanged.
- R8: A cycle with `stat_rd` high clears bits 6, 5 and 4 at the next edge. A flag whose set event falls in the same cycle stays set.
- R9: A load with `ld_en` low while the channel is active and `fifo_empty` is low keeps the enable status high until the first edge at which `fifo_empty` is high. When the channel is not active, the same load clears the enable status at once.
- R10: The active status (bit 1) is set at an edge where `grant` is high while enabled, and it is cleared by `pkt_end`. If the buffer ended with the channel active, `pkt_end` has no effect on it until the next load.
- R11: `dsc_req` is high for exactly the one cycle after an edge at which the enable status falls while the stored load-next bit is set.
- R12: The status word holds the count in bits 31:16, the flags in bits 6, 5 and 4, active in bit 1 and enable in bit 0. Every other bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_stb | input | 1 | Load the channel settings below |
| ld_from_dsc | input | 1 | The load comes from a descriptor fetch |
| ld_en | input | 1 | Requested channel enable |
| ld_next | input | 1 | Fetch the next descriptor when the channel stops |
| ld_addr | input | 32 | Buffer start address |
| ld_len | input | 16 | Buffer length in bytes; 0 means unknown |
| grant | input | 1 | The channel is the granted requester |
| beat | input | 1 | Bus address phase completes this cycle |
| pkt_end | input | 1 | Packet transfer finished |
| dev_end | input | 1 | Device ended the transfer |
| fifo_empty | input | 1 | DMA FIFO holds no data |
| stat_rd | input | 1 | Status word read strobe |
| acc_addr | output | 32 | Address of the current access |
| acc_bytes | output | 3 | Byte width of the current access |
| stat_rdata | output | 32 | Status word |
| rx_len | output | 16 | Bytes moved so far |
| dsc_req | output | 1 | One-cycle request for the next descriptor |

## Verification
The main sweep walks every start offset 0 to 3 against every length 1 to 12. That separates head-only, tail-only, head-and-tail and single-beat buffers, and it checks each beat width and the count after each step. A five-beat unknown-length run from an unaligned address checks the wrap of the count, the received length and the device-ended stop. Separate short sequences cover a read that coincides with the final beat, beats without grant, and disable with and without a pending FIFO drain. They also cover the active flag held after a buffer ends mid-packet.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int ST_EN      = 0;
  localparam int ST_ACT     = 1;
  localparam int ST_TR      = 4;
  localparam int ST_BF      = 5;
  localparam int ST_DSC     = 6;
  localparam int ST_CNT_LSB = 16;

  typedef struct packed {
    logic dsc;
    logic bf;
    logic tr;
  } evt_flags_t;
endpackage

// File: rtl/dct_width.sv
module dct_width #(
  parameter  int CNT_W     = 16,
  parameter  int BUS_BYTES = 4,
  localparam int OFS_W     = $clog2(BUS_BYTES),
  localparam int W_W       = OFS_W + 1
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [CNT_W-1:0] cnt,
  input  logic             unk,
  output logic [W_W-1:0]   bytes
);
  logic [W_W-1:0] room;

  always_comb begin
    room = W_W'(BUS_BYTES) - {1'b0, ofs};
    if (!unk && (cnt < CNT_W'(room))) bytes = cnt[W_W-1:0];
    else                              bytes = room;
  end
endmodule

// File: rtl/dct_count.sv
module dct_count #(
  parameter  int ADDR_W    = 32,
  parameter  int CNT_W     = 16,
  parameter  int BUS_BYTES = 4,
  localparam int OFS_W     = $clog2(BUS_BYTES),
  localparam int W_W       = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              unk_q,
  output logic [W_W-1:0]    acc_bytes,
  output logic [CNT_W-1:0]  moved
);
  logic [ADDR_W-1:0] addr_n;
  logic [CNT_W-1:0]  cnt_n, len_q, len_n;
  logic              unk_n;

  dct_width #(.CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES)) width_i (
    .ofs   (addr_q[OFS_W-1:0]),
    .cnt   (cnt_q),
    .unk   (unk_q),
    .bytes (acc_bytes)
  );

  always_comb begin
    addr_n = addr_q;
    cnt_n  = cnt_q;
    len_n  = len_q;
    unk_n  = unk_q;
    if (ld) begin
      addr_n = ld_addr;
      cnt_n  = ld_len;
      len_n  = ld_len;
      unk_n  = (ld_len == '0);
    end else if (step) begin
      addr_n = addr_q + ADDR_W'(acc_bytes);
      cnt_n  = cnt_q - CNT_W'(acc_bytes);
    end
  end

  // unknown length: count wraps from zero, so bytes moved is its negation
  assign moved = unk_q ? (CNT_W'(0) - cnt_q) : (len_q - cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      unk_q  <= 1'b0;
    end else if (ld || step) begin
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
      len_q  <= len_n;
      unk_q  <= unk_n;
    end
  end
endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic       ld_from_dsc,
  input  logic       ld_en,
  input  logic       ld_next,
  input  logic       buf_end,
  input  logic       dev_end,
  input  logic       pkt_end,
  input  logic       grant,
  input  logic       fifo_empty,
  input  logic       stat_rd,
  output logic       en_q,
  output logic       act_q,
  output logic       drain_q,
  output logic       cut_q,
  output evt_flags_t flg_q,
  output logic       dsc_req_q
);
  logic       en_n, act_n, drain_n, cut_n, nxt_q, nxt_n, dsc_req_n;
  evt_flags_t flg_n;
  logic       dev_stop;

  assign dev_stop = dev_end && en_q;

  always_comb begin
    en_n    = en_q;
    drain_n = drain_q;
    nxt_n   = ld ? ld_next : nxt_q;
    if (ld) begin
      if (ld_en) begin
        en_n    = 1'b1;
        drain_n = 1'b0;
      end else if (act_q && !fifo_empty) begin
        drain_n = 1'b1;
      end else begin
        en_n    = 1'b0;
        drain_n = 1'b0;
      end
    end else if (buf_end || dev_stop || (drain_q && fifo_empty)) begin
      en_n    = 1'b0;
      drain_n = 1'b0;
    end

    act_n = act_q;
    if (grant && en_q) act_n = 1'b1;
    if (pkt_end && !cut_q) act_n = 1'b0;

    cut_n = cut_q;
    if (ld) cut_n = 1'b0;
    else if (buf_end) cut_n = 1'b1;

    flg_n.dsc = (flg_q.dsc && !stat_rd) || (ld && ld_from_dsc);
    flg_n.bf  = (flg_q.bf  && !stat_rd) || buf_end;
    flg_n.tr  = (flg_q.tr  && !stat_rd) || dev_stop;

    dsc_req_n = en_q && !en_n && nxt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      act_q     <= 1'b0;
      drain_q   <= 1'b0;
      cut_q     <= 1'b0;
      nxt_q     <= 1'b0;
      flg_q     <= '0;
      dsc_req_q <= 1'b0;
    end else begin
      en_q      <= en_n;
      act_q     <= act_n;
      drain_q   <= drain_n;
      cut_q     <= cut_n;
      nxt_q     <= nxt_n;
      flg_q     <= flg_n;
      dsc_req_q <= dsc_req_n;
    end
  end
endmodule

// File: rtl/dma_chan_tracker.sv
module dma_chan_tracker
  import dct_pkg::*;
#(
  parameter  int ADDR_W    = 32,
  parameter  int CNT_W     = 16,
  parameter  int BUS_BYTES = 4,
  parameter  int STAT_W    = 32,
  localparam int W_W       = $clog2(BUS_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic              ld_from_dsc,
  input  logic              ld_en,
  input  logic              ld_next,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_len,
  input  logic              grant,
  input  logic              beat,
  input  logic              pkt_end,
  input  logic              dev_end,
  input  logic              fifo_empty,
  input  logic              stat_rd,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [W_W-1:0]    acc_bytes,
  output logic [STAT_W-1:0] stat_rdata,
  output logic [CNT_W-1:0]  rx_len,
  output logic              dsc_req
);
  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic [CNT_W-1:0] cnt_q;
  logic             unk_q, step, buf_end;
  logic             en_q, act_q, drain_q, cut_q;
  evt_flags_t       flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign step    = beat && grant && en_q && (acc_bytes != '0) && !ld_stb;
  assign buf_end = step && !unk_q && (cnt_q == CNT_W'(acc_bytes));

  dct_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES)) count_i (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ld        (ld_stb),
    .ld_addr   (ld_addr),
    .ld_len    (ld_len),
    .step      (step),
    .addr_q    (acc_addr),
    .cnt_q     (cnt_q),
    .unk_q     (unk_q),
    .acc_bytes (acc_bytes),
    .moved     (rx_len)
  );

  dct_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .ld          (ld_stb),
    .ld_from_dsc (ld_from_dsc),
    .ld_en       (ld_en),
    .ld_next     (ld_next),
    .buf_end     (buf_end),
    .dev_end     (dev_end),
    .pkt_end     (pkt_end),
    .grant       (grant),
    .fifo_empty  (fifo_empty),
    .stat_rd     (stat_rd),
    .en_q        (en_q),
    .act_q       (act_q),
    .drain_q     (drain_q),
    .cut_q       (cut_q),
    .flg_q       (flg_q),
    .dsc_req_q   (dsc_req)
  );

  always_comb begin
    stat_rdata                         = '0;
    stat_rdata[ST_CNT_LSB +: CNT_W]    = cnt_q;
    stat_rdata[ST_DSC]                 = flg_q.dsc;
    stat_rdata[ST_BF]                  = flg_q.bf;
    stat_rdata[ST_TR]                  = flg_q.tr;
    stat_rdata[ST_ACT]                 = act_q;
    stat_rdata[ST_EN]                  = en_q;
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int CNT_W = 16,
  parameter int W_W   = 3
) (
  input logic             clk,
  input logic             rst_i_n,
  input logic             step,
  input logic             ld_stb,
  input logic [CNT_W-1:0] cnt_q,
  input logic [W_W-1:0]   acc_bytes,
  input logic             bf,
  input logic             tr,
  input logic             stat_rd,
  input logic             en_q,
  input logic             act_q,
  input logic             drain_q,
  input logic             cut_q,
  input logic             fifo_empty,
  input logic             dev_end,
  input logic             dsc_req
);
  a_r3_step_count: assert property (@(posedge clk) disable iff (!rst_i_n)
    step |=> cnt_q == $past(cnt_q) - CNT_W'($past(acc_bytes)));

  a_r4_bf_at_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(bf) |-> (cnt_q == '0) && !en_q);

  a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(tr) |-> $past(stat_rd));

  a_r9_drain_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (drain_q && !fifo_empty && !ld_stb && !step && !dev_end) |=> en_q);

  a_r10_cut_keeps_act: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cut_q && !ld_stb) |=> act_q);

  a_r11_req_after_drop: assert property (@(posedge clk) disable iff (!rst_i_n)
    dsc_req |-> !en_q && $past(en_q));
endmodule

bind dma_chan_tracker dct_checker #(.CNT_W(CNT_W), .W_W(W_W)) chk_i (
  .clk        (clk),
  .rst_i_n    (rst_i_n),
  .step       (step),
  .ld_stb     (ld_stb),
  .cnt_q      (cnt_q),
  .acc_bytes  (acc_bytes),
  .bf         (flg_q.bf),
  .tr         (flg_q.tr),
  .stat_rd    (stat_rd),
  .en_q       (en_q),
  .act_q      (act_q),
  .drain_q    (drain_q),
  .cut_q      (cut_q),
  .fifo_empty (fifo_empty),
  .dev_end    (dev_end),
  .dsc_req    (dsc_req)
);

// File: tb/dma_chan_tracker_tb_top.sv
module dma_chan_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_stb = 0, ld_from_dsc = 0, ld_en = 0, ld_next = 0;
  logic [31:0] ld_addr = '0;
  logic [15:0] ld_len = '0;
  logic        grant = 0, beat = 0, pkt_end = 0, dev_end = 0, fifo_empty = 1, stat_rd = 0;
  logic [31:0] acc_addr, stat_rdata;
  logic [2:0]  acc_bytes;
  logic [15:0] rx_len;
  logic        dsc_req;
  int          n_chk = 0, n_bad = 0;

  localparam logic [31:0] BASE = 32'h1000_0000;

  always #10 clk = ~clk;

  dma_chan_tracker dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [15:0] l,
                      input logic en, input logic nx, input logic dsc);
    @(negedge clk);
    ld_stb = 1; ld_addr = a; ld_len = l; ld_en = en; ld_next = nx; ld_from_dsc = dsc;
    @(negedge clk);
    ld_stb = 0; ld_from_dsc = 0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rem, ofs, w;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 status", stat_rdata, 0);
    chk("R1 width", {29'd0, acc_bytes}, 0);
    chk("R1 rxlen", {16'd0, rx_len}, 0);
    chk("R1 req", {31'd0, dsc_req}, 0);

    // sweep offsets and lengths
    for (int a = 0; a < 4; a++) begin
      for (int l = 1; l <= 12; l++) begin
        load(BASE + a, l[15:0], 1, 1, 1);
        chk("R7 dsc flag", {31'd0, stat_rdata[6]}, 1);
        chk("R12 count field", {16'd0, stat_rdata[31:16]}, l);
        rem = l; ofs = a;
        grant = 1; beat = 1;
        while (rem > 0) begin
          w = (4 - ofs < rem) ? 4 - ofs : rem;
          chk("R2 width", {29'd0, acc_bytes}, w);
          @(negedge clk);
          rem -= w; ofs = (ofs + w) % 4;
          chk("R3 count", {16'd0, stat_rdata[31:16]}, rem);
        end
        beat = 0; grant = 0;
        chk("R4 bf and en", {26'd0, stat_rdata[5:0]}, 32'h22);
        chk("R3 address", acc_addr, BASE + a + l);
        chk("R11 req", {31'd0, dsc_req}, 1);
        pkt_end = 1;
        @(negedge clk);
        pkt_end = 0;
        chk("R10 act held", {31'd0, stat_rdata[1]}, 1);
        chk("R11 single pulse", {31'd0, dsc_req}, 0);
        stat_rd = 1;
        chk("R8 read value", {25'd0, stat_rdata[6:0]}, 32'h62);
        @(negedge clk);
        stat_rd = 0;
        chk("R8 cleared", {25'd0, stat_rdata[6:0]}, 32'h02);
      end
    end

    // unknown length from offset 1: widths 3,4,4,4,4
    load(BASE + 1, 16'd0, 1, 1, 0);
    chk("R7 sw load no flag", {31'd0, stat_rdata[6]}, 0);
    grant = 1; beat = 1;
    for (int i = 0; i < 5; i++) begin
      chk("R5 width", {29'd0, acc_bytes}, (i == 0) ? 3 : 4);
      @(negedge clk);
    end
    beat = 0; grant = 0;
    chk("R5 wrapped count", {16'd0, stat_rdata[31:16]}, 32'hFFED);
    chk("R5 rx len", {16'd0, rx_len}, 19);
    chk("R5 no bf, still enabled", {31'd0, stat_rdata[5]}, 0);
    chk("R5 enabled", {31'd0, stat_rdata[0]}, 1);
    dev_end = 1;
    @(negedge clk);
    dev_end = 0;
    chk("R6 tr set en clr", {30'd0, stat_rdata[4], stat_rdata[0]}, 2);
    chk("R11 req on dev end", {31'd0, dsc_req}, 1);

    // read coincides with final beat
    load(BASE, 16'd2, 1, 0, 0);
    grant = 1; beat = 1; stat_rd = 1;
    @(negedge clk);
    grant = 0; beat = 0; stat_rd = 0;
    chk("R8 set wins", {31'd0, stat_rdata[5]}, 1);
    chk("R8 tr cleared", {31'd0, stat_rdata[4]}, 0);
    chk("R11 no req without next", {31'd0, dsc_req}, 0);

    // beats without grant, active set/clear
    load(BASE, 16'd8, 1, 0, 0);
    pkt_end = 1;
    @(negedge clk);
    pkt_end = 0;
    chk("R10 act cleared", {31'd0, stat_rdata[1]}, 0);
    beat = 1;
    repeat (2) @(negedge clk);
    beat = 0;
    chk("R3 no grant ignored", {16'd0, stat_rdata[31:16]}, 8);
    grant = 1;
    @(negedge clk);
    grant = 0;
    chk("R10 act set", {31'd0, stat_rdata[1]}, 1);

    // disable while active with FIFO data
    fifo_empty = 0;
    load(BASE, 16'd8, 0, 0, 0);
    chk("R9 held", {31'd0, stat_rdata[0]}, 1);
    repeat (3) @(negedge clk);
    chk("R9 still held", {31'd0, stat_rdata[0]}, 1);
    fifo_empty = 1;
    @(negedge clk);
    chk("R9 drained", {31'd0, stat_rdata[0]}, 0);

    // disable while idle
    pkt_end = 1;
    @(negedge clk);
    pkt_end = 0;
    load(BASE, 16'd8, 1, 1, 0);
    fifo_empty = 0;
    load(BASE, 16'd8, 0, 1, 0);
    chk("R9 idle immediate", {31'd0, stat_rdata[0]}, 0);
    chk("R11 req on disable", {31'd0, dsc_req}, 1);
    chk("R12 spare bits", {16'd0, stat_rdata[15:7], stat_rdata[3:2]}, 0);
    fifo_empty = 1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule